// File: doc/BRIEF.md
# MSI Ring Logger

This block turns inbound message-signalled interrupt writes into records in a circular buffer that lives in system memory. Each accepted interrupt word becomes one 16-byte record, written through a memory-write master port. The block also raises one level interrupt toward the host processor for as long as records are waiting to be read.

Software sets up the block through a small word-addressed register bus. It programs a 64-bit buffer base address, picks a power-of-two buffer size and sets the enable bits. To drain the ring, software reads the hardware write offset, consumes records starting at its own read offset, and then writes the new read offset back. When the ring fills up, the block either drops new interrupts or overwrites old records, as a control bit selects. A sticky flag records that the ring was full.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_out` and `mem_valid` are low and `msi_ready` is high.
- R2: The register map is: control at word 0, base address bits 63:32 at word 3, base address bits 31:0 at word 4, read offset at word 5 and write offset at word 6. Any other word reads 0. The control word keeps only these bits: 0 (enable), 1 (full detect), 3 (interrupt enable), 4 (stop when full) and 9:8 (size code). Its other bits read 0, except bit 31, which is the overflow flag.
- R3: An MSI word accepted while enable is set produces exactly one memory write. That write goes to base + write offset, with the 128-bit record holding the word in bits 31:0 (byte 0 in bits 7:0, little-endian) and zero in bits 127:32. Address and data stay stable while `mem_valid` is high and `mem_ready` is low.
- R4: The buffer size is 32 KB shifted left by the size code (0 to 3 gives 32, 64, 128 or 256 KB). The write offset advances by 16 when a memory write completes, and it wraps to 0 at the end of the buffer.
- R5: `msi_ready` is low from the cycle after an MSI is accepted for recording until the cycle after the memory handshake, so at most one record write is in flight.
- R6: While enable is clear, MSI words are accepted and discarded: no memory write happens and the write offset does not change.
- R7: The ring is full when (write offset + 16) mod size equals the read offset. If stop-when-full is set, an MSI arriving while the ring is full is dropped without a memory write.
- R8: If stop-when-full is clear, an MSI arriving while the ring is full is recorded, overwriting the oldest slot, and the read offset does not change.
- R9: When full detect is set, an MSI arriving while the ring is full sets overflow flag bit 31 of the control word. The flag stays set until software writes the control word with bit 31 set.
- R10: `irq_out` is high exactly when enable and interrupt enable are both set and the read offset differs from the write offset.
- R11: Writes to the write-offset register are ignored. A value written to the read-offset register is stored ANDed with (size - 1) with bits 3:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| msi_valid | input | 1 | Inbound MSI word valid |
| msi_ready | output | 1 | Block can take an MSI word |
| msi_data | input | 32 | Inbound MSI data word |
| mem_valid | output | 1 | Record write request |
| mem_ready | input | 1 | Memory accepts the record write |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The hardest state to reach from the ports is a full ring, because filling it with traffic takes thousands of records. The stimulus gets there another way: it writes a read offset one slot ahead of the write offset, which makes the ring full at once, and then runs both the drop policy and the overwrite policy from that state. The wrap at the end of the buffer is reached by streaming a whole 32 KB ring with the read offset parked at zero. On the way, the last slot meets the full condition and the overwrite path. A behavioural model checks every cycle, including random interrupt traffic and random memory back-pressure.

// File: rtl/msi_ring_pkg.sv
// Shared register offsets, control-bit positions and the control field type
// for the MSI ring logger.
package msi_ring_pkg;

    localparam int REG_AW = 3;

    // Word offsets on the register bus.
    localparam logic [REG_AW-1:0] REG_CTRL    = 3'd0;
    localparam logic [REG_AW-1:0] REG_BASE_HI = 3'd3;
    localparam logic [REG_AW-1:0] REG_BASE_LO = 3'd4;
    localparam logic [REG_AW-1:0] REG_RD_OFS  = 3'd5;
    localparam logic [REG_AW-1:0] REG_WR_OFS  = 3'd6;

    // Bit positions in the control word.
    localparam int CB_EN      = 0;
    localparam int CB_FULLDET = 1;
    localparam int CB_IRQEN   = 3;
    localparam int CB_STOP    = 4;
    localparam int CB_SIZE    = 8;
    localparam int CB_OVF     = 31;

    typedef struct packed {
        logic [1:0] size;
        logic       stop;
        logic       irq_en;
        logic       full_det;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/msi_ring_regs.sv
// Register file of the MSI ring logger: control, base address, read offset and
// the sticky overflow flag, plus the readback mux and the host interrupt.
// Assumes: the write offset comes from the writer already masked to the size.
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int OFS_W       = 18,
    parameter int MIN_SHIFT   = 15,
    parameter int ENTRY_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [OFS_W-1:0]  wofs_eff,
    input  logic              ovf_set,
    output ctrl_t             ctrl_q,
    output logic [63:0]       base_q,
    output logic [OFS_W-1:0]  ofs_mask,
    output logic [OFS_W-1:0]  rofs_eff,
    output logic              irq_out
);
    localparam logic [OFS_W-1:0] ALIGN_CLR = ~OFS_W'((1 << ENTRY_SHIFT) - 1);

    logic [31:0]      base_hi_q, base_lo_q;
    logic [OFS_W-1:0] rofs_q;
    logic             ovf_q;
    logic [OFS_W:0]   span;
    logic [31:0]      ctrl_word;

    // Offset mask from the size code: (size - 1) with the entry bits cleared.
    always_comb begin
        span     = (OFS_W+1)'(1) << (MIN_SHIFT + int'(ctrl_q.size));
        ofs_mask = OFS_W'(span - 1'b1) & ALIGN_CLR;
    end

    assign rofs_eff = rofs_q & ofs_mask;
    assign base_q   = {base_hi_q, base_lo_q};

    // Software-visible register state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            base_hi_q <= '0;
            base_lo_q <= '0;
            rofs_q    <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_CTRL: begin
                    ctrl_q.en       <= reg_wdata[CB_EN];
                    ctrl_q.full_det <= reg_wdata[CB_FULLDET];
                    ctrl_q.irq_en   <= reg_wdata[CB_IRQEN];
                    ctrl_q.stop     <= reg_wdata[CB_STOP];
                    ctrl_q.size     <= reg_wdata[CB_SIZE+1:CB_SIZE];
                end
                REG_BASE_HI: base_hi_q <= reg_wdata;
                REG_BASE_LO: base_lo_q <= reg_wdata;
                REG_RD_OFS:  rofs_q    <= reg_wdata[OFS_W-1:0] & ofs_mask;
                default: ;
            endcase
        end
    end

    // Sticky overflow flag: a set event wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (ovf_set)
            ovf_q <= 1'b1;
        else if (reg_we && reg_addr == REG_CTRL && reg_wdata[CB_OVF])
            ovf_q <= 1'b0;
    end

    // Assemble the control word for readback.
    always_comb begin
        ctrl_word                      = '0;
        ctrl_word[CB_EN]               = ctrl_q.en;
        ctrl_word[CB_FULLDET]          = ctrl_q.full_det;
        ctrl_word[CB_IRQEN]            = ctrl_q.irq_en;
        ctrl_word[CB_STOP]             = ctrl_q.stop;
        ctrl_word[CB_SIZE+1:CB_SIZE]   = ctrl_q.size;
        ctrl_word[CB_OVF]              = ovf_q;
    end

    // Readback mux; unmapped words read zero.
    always_comb begin
        case (reg_addr)
            REG_CTRL:    reg_rdata = ctrl_word;
            REG_BASE_HI: reg_rdata = base_hi_q;
            REG_BASE_LO: reg_rdata = base_lo_q;
            REG_RD_OFS:  reg_rdata = {{(32-OFS_W){1'b0}}, rofs_eff};
            REG_WR_OFS:  reg_rdata = {{(32-OFS_W){1'b0}}, wofs_eff};
            default:     reg_rdata = '0;
        endcase
    end

    // Host interrupt: pending records while enabled.
    assign irq_out = ctrl_q.en && ctrl_q.irq_en && (rofs_eff != wofs_eff);

endmodule

// File: rtl/msi_ring_writer.sv
// Record writer of the MSI ring logger: takes MSI words, applies the enable and
// full policy, issues one 128-bit record write at a time and advances the write
// offset when that write completes.
// Assumes: the memory side holds mem_ready meaning only while mem_valid is high.
module msi_ring_writer
    import msi_ring_pkg::*;
#(
    parameter int OFS_W       = 18,
    parameter int DATA_W      = 32,
    parameter int REC_W       = 128,
    parameter int ENTRY_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    output logic              msi_ready,
    input  logic [DATA_W-1:0] msi_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [63:0]       mem_addr,
    output logic [REC_W-1:0]  mem_data,
    input  ctrl_t             ctrl_q,
    input  logic [63:0]       base_q,
    input  logic [OFS_W-1:0]  ofs_mask,
    input  logic [OFS_W-1:0]  rofs_eff,
    output logic [OFS_W-1:0]  wofs_eff,
    output logic              ovf_set
);
    localparam logic [OFS_W-1:0] STEP = OFS_W'(1 << ENTRY_SHIFT);

    logic              busy_q;
    logic [OFS_W-1:0]  wofs_q;
    logic [63:0]       addr_q;
    logic [DATA_W-1:0] data_q;
    logic [OFS_W-1:0]  next_slot;
    logic              take, full, commit, done;

    assign wofs_eff  = wofs_q & ofs_mask;
    assign next_slot = (wofs_eff + STEP) & ofs_mask;
    assign full      = (next_slot == rofs_eff);
    assign msi_ready = !busy_q;
    assign take      = msi_valid && !busy_q;
    assign commit    = take && ctrl_q.en && !(full && ctrl_q.stop);
    assign done      = busy_q && mem_ready;
    assign ovf_set   = take && ctrl_q.en && ctrl_q.full_det && full;

    assign mem_valid = busy_q;
    assign mem_addr  = addr_q;
    assign mem_data  = {{(REC_W-DATA_W){1'b0}}, data_q};

    // Capture a record on commit; retire it and step the offset on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wofs_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (commit) begin
            busy_q <= 1'b1;
            addr_q <= base_q + 64'(wofs_eff);
            data_q <= msi_data;
        end else if (done) begin
            busy_q <= 1'b0;
            wofs_q <= next_slot;
        end
    end

endmodule

// File: rtl/msi_ring_ctrl.sv
// Top of the MSI ring logger: joins the register file and the record writer.
// Assumes: a single clock domain, a 64-bit memory address space and a
// word-addressed register bus with combinational reads.
module msi_ring_ctrl
    import msi_ring_pkg::*;
#(
    parameter int OFS_W       = 18,
    parameter int MIN_SHIFT   = 15,
    parameter int ENTRY_SHIFT = 4,
    parameter int DATA_W      = 32,
    parameter int REC_W       = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              msi_valid,
    output logic              msi_ready,
    input  logic [DATA_W-1:0] msi_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [63:0]       mem_addr,
    output logic [REC_W-1:0]  mem_data,
    output logic              irq_out
);
    ctrl_t            ctrl_q;
    logic [63:0]      base_q;
    logic [OFS_W-1:0] ofs_mask, rofs_eff, wofs_eff;
    logic             ovf_set;

    msi_ring_regs #(
        .OFS_W(OFS_W), .MIN_SHIFT(MIN_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wofs_eff(wofs_eff), .ovf_set(ovf_set),
        .ctrl_q(ctrl_q), .base_q(base_q), .ofs_mask(ofs_mask),
        .rofs_eff(rofs_eff), .irq_out(irq_out)
    );

    msi_ring_writer #(
        .OFS_W(OFS_W), .DATA_W(DATA_W), .REC_W(REC_W), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_writer (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_data(msi_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .ctrl_q(ctrl_q), .base_q(base_q), .ofs_mask(ofs_mask),
        .rofs_eff(rofs_eff), .wofs_eff(wofs_eff), .ovf_set(ovf_set)
    );

endmodule

// File: rtl/msi_ring_chk.sv
// Protocol and policy checker for the MSI ring logger, bound to the top module.
module msi_ring_chk #(
    parameter int OFS_W = 18,
    parameter int REC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msi_valid,
    input logic             msi_ready,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [63:0]      mem_addr,
    input logic [REC_W-1:0] mem_data,
    input logic             irq_out,
    input logic             ctrl_en,
    input logic [OFS_W-1:0] wofs_eff
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R3
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !msi_ready); // R5
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> msi_ready); // R5
    AST_WOFS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> wofs_eff != $past(wofs_eff)); // R4
    AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && msi_ready && !ctrl_en |=> !mem_valid); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !irq_out); // R10
endmodule

bind msi_ring_ctrl msi_ring_chk #(.OFS_W(OFS_W), .REC_W(REC_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .msi_valid(msi_valid), .msi_ready(msi_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .irq_out(irq_out), .ctrl_en(ctrl_q.en), .wofs_eff(wofs_eff)
);

// File: tb/sim_msi_ring_ctrl.sv
// Bench for msi_ring_ctrl: directed tests plus random traffic, with a
// behavioural model compared on every clock.
module sim_msi_ring_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msi_valid = 1'b0;
    logic         msi_ready;
    logic [31:0]  msi_data = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    int ready_mode = 0;   // 0: always ready, 1: random, 2: stalled
    bit done_flag = 0;

    always #2 clk = ~clk;  // 250 MHz

    msi_ring_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_data(msi_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .irq_out(irq_out)
    );

    // Memory responder.
    logic [127:0] mem [longint unsigned];
    always @(posedge clk) if (rst_n && mem_valid && mem_ready) mem[mem_addr] = mem_data;
    always @(negedge clk)
        mem_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : 1'($urandom_range(0, 1));

    // Behavioural reference model.
    logic [31:0] m_ctrl, m_hi, m_lo, m_rofs, m_wofs, m_data;
    logic [63:0] m_addr;
    bit m_ovf, m_busy;

    function automatic logic [31:0] mk(input logic [31:0] c);
        return ((32'd32768 << c[9:8]) - 32'd1) & ~32'hF;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return (m_ctrl & 32'h31B) | (m_ovf ? 32'h8000_0000 : 32'h0);
            3'd3: return m_hi;
            3'd4: return m_lo;
            3'd5: return m_rofs & mk(m_ctrl);
            3'd6: return m_wofs & mk(m_ctrl);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_hi = 0; m_lo = 0; m_rofs = 0; m_wofs = 0; m_data = 0;
            m_addr = 0; m_ovf = 0; m_busy = 0;
        end else begin
            logic [31:0] mask, weff, reff, nxt;
            bit full, take, en, set_o, commit, fin, clr;
            mask = mk(m_ctrl);
            weff = m_wofs & mask;
            reff = m_rofs & mask;
            nxt  = (weff + 32'd16) & mask;
            full = (nxt == reff);
            en   = m_ctrl[0];
            take = msi_valid && !m_busy;
            set_o  = take && en && full && m_ctrl[1];
            commit = take && en && !(full && m_ctrl[4]);
            fin    = m_busy && mem_ready;
            clr    = 0;
            if (commit) begin
                m_busy = 1; m_addr = {m_hi, m_lo} + 64'(weff); m_data = msi_data;
            end else if (fin) begin
                m_busy = 0; m_wofs = nxt;
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: begin m_ctrl = reg_wdata & 32'h31B; clr = reg_wdata[31]; end
                    3'd3: m_hi = reg_wdata;
                    3'd4: m_lo = reg_wdata;
                    3'd5: m_rofs = reg_wdata & mask;
                    default: ;
                endcase
            end
            if (set_o) m_ovf = 1;
            else if (clr) m_ovf = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done_flag) begin
            logic [31:0] mask;
            bit exp_irq;
            mask = mk(m_ctrl);
            exp_irq = m_ctrl[0] && m_ctrl[3] && ((m_rofs & mask) != (m_wofs & mask));
            chk(irq_out == exp_irq, "R10 irq_out", 128'(irq_out), 128'(exp_irq));
            chk(msi_ready == !m_busy, "R5 msi_ready", 128'(msi_ready), 128'(!m_busy));
            chk(mem_valid == m_busy, "R3 mem_valid", 128'(mem_valid), 128'(m_busy));
            if (m_busy) begin
                chk(mem_addr == m_addr, "R3 mem_addr", 128'(mem_addr), 128'(m_addr));
                chk(mem_data == {96'h0, m_data}, "R3 mem_data", mem_data, {96'h0, m_data});
            end
            chk(reg_rdata == m_read(reg_addr), "R2 reg_rdata", 128'(reg_rdata), 128'(m_read(reg_addr)));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic send(input logic [31:0] d);
        @(negedge clk);
        while (!msi_ready) @(negedge clk);
        msi_valid = 1; msi_data = d;
        @(negedge clk);
        msi_valid = 0;
        for (int k = 0; k < 40 && mem_valid; k++) @(negedge clk);
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v == e, tag, 128'(v), 128'(e));
    endtask

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [63:0] BASE = 64'h1_8000_0000;

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        @(negedge clk);
        chk(irq_out == 0 && mem_valid == 0 && msi_ready == 1, "R1 reset outputs",
            128'({irq_out, mem_valid, msi_ready}), 128'(3'b001));
        for (int a = 0; a < 8; a++) expect_reg(3'(a), 32'h0, "R1 reset regs");

        // R2: register map and control bit mask
        wr(3'd3, 32'h1);
        wr(3'd4, 32'h8000_0000);
        wr(3'd0, 32'h7FFF_FFFF);
        expect_reg(3'd0, 32'h31B, "R2 ctrl mask");
        expect_reg(3'd3, 32'h1, "R2 base hi");
        expect_reg(3'd4, 32'h8000_0000, "R2 base lo");
        wr(3'd1, 32'hDEAD);
        expect_reg(3'd1, 32'h0, "R2 unmapped");
        wr(3'd0, 32'h109);  // en, irq_en, 64 KB

        // R3: record with stalled memory
        ready_mode = 2;
        @(negedge clk);
        msi_valid = 1; msi_data = 32'hABCD_1234;
        @(negedge clk);
        msi_valid = 0;
        repeat (3) @(negedge clk);
        chk(mem_valid && !msi_ready, "R5 stall in flight", 128'({mem_valid, msi_ready}), 128'(2'b10));
        ready_mode = 0;
        repeat (3) @(negedge clk);
        chk(mem.exists(BASE) && mem[BASE] == {96'h0, 32'hABCD_1234}, "R3 record content",
            mem.exists(BASE) ? mem[BASE] : 128'hX, {96'h0, 32'hABCD_1234});
        expect_reg(3'd6, 32'h10, "R4 wofs step");
        chk(irq_out == 1, "R10 irq pending", 128'(irq_out), 128'(1));

        // R10/R11: drain and masking
        wr(3'd5, 32'h10);
        @(negedge clk);
        chk(irq_out == 0, "R10 irq drained", 128'(irq_out), 128'(0));
        wr(3'd5, 32'h1237);
        expect_reg(3'd5, 32'h1230, "R11 rofs align");
        wr(3'd5, 32'h12345);
        expect_reg(3'd5, 32'h2340, "R11 rofs size mask");
        wr(3'd5, 32'h10);
        wr(3'd6, 32'h500);
        expect_reg(3'd6, 32'h10, "R11 wofs write ignored");

        // R6: disabled drop
        wr(3'd0, 32'h108);
        send(32'h77);
        expect_reg(3'd6, 32'h10, "R6 wofs unchanged");
        chk(!mem.exists(BASE + 64'h10), "R6 no memory write", 128'(mem.exists(BASE + 64'h10)), 128'(0));

        // R7/R9: full with stop
        wr(3'd0, 32'h11B);
        wr(3'd5, 32'h20);
        send(32'h88);
        expect_reg(3'd6, 32'h10, "R7 full drop");
        chk(!mem.exists(BASE + 64'h10), "R7 no write", 128'(mem.exists(BASE + 64'h10)), 128'(0));
        expect_reg(3'd0, 32'h8000_011B, "R9 ovf set");
        wr(3'd0, 32'h8000_011B);
        expect_reg(3'd0, 32'h11B, "R9 ovf cleared");

        // R8: full with overwrite
        wr(3'd0, 32'h10B);
        send(32'h55);
        chk(mem.exists(BASE + 64'h10) && mem[BASE + 64'h10] == 128'h55, "R8 overwrite record",
            mem.exists(BASE + 64'h10) ? mem[BASE + 64'h10] : 128'hX, 128'h55);
        expect_reg(3'd6, 32'h20, "R8 wofs advanced");
        expect_reg(3'd5, 32'h20, "R8 rofs unchanged");
        expect_reg(3'd0, 32'h8000_010B, "R9 ovf on overwrite");

        // R4: wrap of a 32 KB ring
        wr(3'd0, 32'h8000_000B);
        wr(3'd5, 32'h0);
        for (int i = 0; i < 2046; i++) send(32'(i + 1));
        expect_reg(3'd6, 32'h0, "R4 wrap to zero");
        chk(mem.exists(BASE + 64'h7FF0) && mem[BASE + 64'h7FF0] == 128'd2046, "R4 last slot",
            mem.exists(BASE + 64'h7FF0) ? mem[BASE + 64'h7FF0] : 128'hX, 128'd2046);
        wr(3'd0, 32'h30B);
        wr(3'd5, 32'h3FFFF);
        expect_reg(3'd5, 32'h3FFF0, "R4 256 KB mask");

        // R10: quiesce with records pending
        wr(3'd5, 32'h0);
        send(32'h99);
        chk(irq_out == 1, "R10 pending before quiesce", 128'(irq_out), 128'(1));
        wr(3'd0, 32'h300);
        @(negedge clk);
        chk(irq_out == 0, "R10 quiesced", 128'(irq_out), 128'(0));

        // Random traffic with back-pressure, compared by the model.
        wr(3'd0, 32'h11B);
        ready_mode = 1;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            msi_valid = 1'($urandom_range(0, 1));
            msi_data  = $urandom;
            reg_addr  = 3'($urandom_range(0, 6));
            if ($urandom_range(0, 15) == 0) begin
                reg_we = 1; reg_addr = 3'd5; reg_wdata = $urandom;
            end else reg_we = 0;
        end
        @(negedge clk);
        msi_valid = 0; reg_we = 0; ready_mode = 0;
        repeat (10) @(negedge clk);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule